// File: doc/BRIEF.md
# Timer Capture/Compare Unit

This unit sits beside a free-running timer that lives outside it. A 4-bit mode code, written through a small register port, chooses the unit's behaviour. The unit can be switched off. In capture mode it snapshots the timer value when a chosen input event occurs. In compare mode it watches the timer for a stored value and acts when the timer reaches that value. One 16-bit holding register serves both modes. In capture modes it holds the most recent snapshot. In compare modes it holds the match target.

Capture events come from a pin or from an alternate time-stamp pulse. The pin passes through a synchronizer and then an edge detector. The alternate pulse is already synchronous and replaces the pin when a select input is high. The events can be counted so that only every 4th or every 16th one captures. A compare match can toggle the output pin, force it to a level, do nothing but raise the interrupt flag, or send a one-cycle pulse that the timer uses to restart itself. Every capture and every match sets a sticky interrupt flag, and software clears that flag with a strobe.

Top module: `tcc_unit`

## Requirements
- R1: After reset, out_pin, out_en, irq_flag and special_evt are 0, and both read selections return 0.
- R2: Mode codes 0000, 0001, 0011 and 11xx are inactive. They make no capture and no match, the flag is not set, and out_pin and out_en are 0.
- R3: Mode 0100 captures on falling pin edges. Rising edges do nothing. The register takes the timer value present at the third rising clock edge after cap_pin falls, and irq_flag rises with it.
- R4: Mode 0101 captures on rising pin edges, with the same three-edge latency as R3. Falling edges do nothing.
- R5: Mode 0110 captures on every 4th qualifying event and mode 0111 on every 16th. Each write of the mode field restarts the count from zero.
- R6: While alt_sel is 1, each clock cycle with alt_evt high counts as one event and is captured at that clock edge. In this state pin edges are ignored.
- R7: Mode 0010 sets out_pin to 0 when the mode is written and inverts out_pin on each match. out_en is 1 in this mode.
- R8: Mode 1000 sets out_pin to 0 on entry and to 1 on a match. Mode 1001 sets out_pin to 1 on entry and to 0 on a match. out_en is 1 in both modes.
- R9: Mode 1010 sets only the flag on a match. out_en is 0 and out_pin does not change.
- R10: Mode 1011 sets the flag on a match and raises special_evt for exactly one cycle. special_evt goes high at the clock edge that ends the match cycle.
- R11: A match fires once, in the cycle where the timer first equals the register. It does not fire again while the timer stays equal. Its effects appear at the clock edge that ends that cycle.
- R12: irq_flag stays set until a cycle with irq_clr high. If a capture or match falls in that same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 = mode field (data bits 3:0), 1 = holding register |
| wr_data | input | 16 | Write data |
| rd_sel | input | 1 | Read selection: 0 = mode field zero-extended, 1 = holding register |
| rd_data | output | 16 | Read data |
| timer_val | input | 16 | Current timer count |
| cap_pin | input | 1 | Asynchronous capture pin |
| alt_sel | input | 1 | Selects alt_evt as the capture source |
| alt_evt | input | 1 | Synchronous alternate time-stamp event |
| out_pin | output | 1 | Compare output level |
| out_en | output | 1 | High when the unit owns the output pin |
| irq_flag | output | 1 | Sticky interrupt flag |
| irq_clr | input | 1 | Clear strobe for irq_flag |
| special_evt | output | 1 | One-cycle timer reset request |

## Verification
Two things can land on the interrupt flag in the same cycle: a compare match or capture that sets it, and a software clear that resets it. The bench loads the timer two counts below the match target and lets it run. It then raises irq_clr in exactly the cycle in which the timer equals the target. The flag must read 1 afterwards. A later clear on its own must bring it to 0, and the flag must hold across idle cycles in between. Mode writes that land alongside pending events are tested as well, through the restart of the prescaler count.

// File: rtl/tcc_pkg.sv
package tcc_pkg;

  localparam int unsigned MODE_W = 4;

  typedef logic [MODE_W-1:0] tcc_mode_t;

  localparam tcc_mode_t MD_OFF       = 4'h0;
  localparam tcc_mode_t MD_CMP_TGL   = 4'h2;
  localparam tcc_mode_t MD_CAP_FALL  = 4'h4;
  localparam tcc_mode_t MD_CAP_RISE  = 4'h5;
  localparam tcc_mode_t MD_CAP_DIVA  = 4'h6;
  localparam tcc_mode_t MD_CAP_DIVB  = 4'h7;
  localparam tcc_mode_t MD_CMP_HI    = 4'h8;
  localparam tcc_mode_t MD_CMP_LO    = 4'h9;
  localparam tcc_mode_t MD_CMP_IRQ   = 4'hA;
  localparam tcc_mode_t MD_CMP_SPEC  = 4'hB;

  typedef enum logic [1:0] {
    PS_ONE = 2'd0,
    PS_A   = 2'd1,
    PS_B   = 2'd2
  } ps_sel_e;

  function automatic logic mode_is_cap(tcc_mode_t m);
    return m[3:2] == 2'b01;
  endfunction

  function automatic logic mode_is_cmp(tcc_mode_t m);
    return (m == MD_CMP_TGL) || (m[3:2] == 2'b10);
  endfunction

  function automatic logic mode_drives_pin(tcc_mode_t m);
    return (m == MD_CMP_TGL) || (m == MD_CMP_HI) || (m == MD_CMP_LO);
  endfunction

endpackage

// File: rtl/tcc_edge_sync.sv
module tcc_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              prev_q;
  logic              lvl;

  generate
    if (STAGES == 1) begin : g_one
      assign sync_d = pin_i;
    end else begin : g_many
      assign sync_d = {sync_q[STAGES-2:0], pin_i};
    end
  endgenerate

  assign lvl = sync_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= lvl;
    end
  end

  always_comb begin
    rise_o = lvl & ~prev_q;
    fall_o = ~lvl & prev_q;
  end

  // R4: one edge of the synchronized level never reports twice
  p_rise_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);

  // R3: same for falling edges
  p_fall_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o);

endmodule

// File: rtl/tcc_cap_prescale.sv
module tcc_cap_prescale
  import tcc_pkg::*;
#(
  parameter int unsigned DIV_A = 4,
  parameter int unsigned DIV_B = 16
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    clr_i,
  input  logic    evt_i,
  input  ps_sel_e sel_i,
  output logic    fire_o
);

  localparam int unsigned CNT_W = (DIV_B > 2) ? $clog2(DIV_B) : 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] lim;
  logic             at_lim;
  logic             cnt_en;

  always_comb begin
    case (sel_i)
      PS_A:    lim = CNT_W'(DIV_A - 1);
      PS_B:    lim = CNT_W'(DIV_B - 1);
      default: lim = '0;
    endcase
  end

  always_comb begin
    at_lim = (cnt_q == lim);
    fire_o = evt_i & at_lim & ~clr_i;
    cnt_en = clr_i | evt_i;
    if (clr_i)       cnt_d = '0;
    else if (at_lim) cnt_d = '0;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R5: the event count never passes the selected division limit
  p_cnt_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= lim);

  // R5: a clear leaves the count at zero for the following cycle
  p_clr_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0));

endmodule

// File: rtl/tcc_cmp_action.sv
module tcc_cmp_action
  import tcc_pkg::*;
#(
  parameter int unsigned TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  tcc_mode_t     mode_i,
  input  logic          mode_wr_i,
  input  tcc_mode_t     mode_wdata_i,
  input  logic [TW-1:0] timer_i,
  input  logic [TW-1:0] ref_i,
  output logic          match_o,
  output logic          pin_o,
  output logic          spec_o
);

  logic eq;
  logic eq_q, eq_d;
  logic pin_q, pin_d, pin_en;
  logic spec_q, spec_d;
  logic cmp_on;

  always_comb begin
    cmp_on  = mode_is_cmp(mode_i);
    eq      = (timer_i == ref_i);
    match_o = cmp_on & ~mode_wr_i & eq & ~eq_q;
    eq_d    = mode_wr_i ? 1'b0 : eq;
    spec_d  = match_o & (mode_i == MD_CMP_SPEC);
  end

  always_comb begin
    pin_en = mode_wr_i | match_o | ~cmp_on;
    pin_d  = pin_q;
    if (mode_wr_i) begin
      pin_d = (mode_wdata_i == MD_CMP_LO);
    end else if (!cmp_on) begin
      pin_d = 1'b0;
    end else if (match_o) begin
      case (mode_i)
        MD_CMP_TGL: pin_d = ~pin_q;
        MD_CMP_HI:  pin_d = 1'b1;
        MD_CMP_LO:  pin_d = 1'b0;
        default:    pin_d = pin_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eq_q   <= 1'b0;
      spec_q <= 1'b0;
    end else begin
      eq_q   <= eq_d;
      spec_q <= spec_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pin_q <= 1'b0;
    else if (pin_en) pin_q <= pin_d;
  end

  assign pin_o  = pin_q;
  assign spec_o = spec_q;

  // R11: a match never repeats in the next cycle
  p_single_match_r11: assert property (@(posedge clk) disable iff (!rst_n)
    match_o |=> !match_o);

  // R10: the special-event request lasts a single cycle
  p_spec_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
    spec_q |=> !spec_q);

  // R8: a match in force-high mode leaves the pin high
  p_force_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (match_o && mode_i == MD_CMP_HI) |=> pin_q);

  // R8: a match in force-low mode leaves the pin low
  p_force_lo_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (match_o && mode_i == MD_CMP_LO) |=> !pin_q);

endmodule

// File: rtl/tcc_unit.sv
module tcc_unit
  import tcc_pkg::*;
#(
  parameter int unsigned TW          = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DIV_A       = 4,
  parameter int unsigned DIV_B       = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [TW-1:0] wr_data,
  input  logic          rd_sel,
  output logic [TW-1:0] rd_data,
  input  logic [TW-1:0] timer_val,
  input  logic          cap_pin,
  input  logic          alt_sel,
  input  logic          alt_evt,
  output logic          out_pin,
  output logic          out_en,
  output logic          irq_flag,
  input  logic          irq_clr,
  output logic          special_evt
);

  localparam int unsigned PAD_W = TW - MODE_W;

  tcc_mode_t     mode_q;
  tcc_mode_t     mode_wdata;
  logic          mode_wr;
  logic          val_wr;
  logic [TW-1:0] val_q, val_d;
  logic          val_en;
  logic          irq_q, irq_d;
  logic          cap_on;
  logic          pin_rise, pin_fall;
  logic          src_evt;
  logic          ps_evt, ps_clr, cap_fire;
  ps_sel_e       ps_sel;
  logic          cmp_match;
  logic          flag_set;

  // write decode
  always_comb begin
    mode_wr    = wr_en & ~wr_sel;
    val_wr     = wr_en &  wr_sel;
    mode_wdata = wr_data[MODE_W-1:0];
    cap_on     = mode_is_cap(mode_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= MD_OFF;
    else if (mode_wr) mode_q <= mode_wdata;
  end

  // capture source
  tcc_edge_sync #(
    .STAGES (SYNC_STAGES)
  ) i_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (cap_pin),
    .rise_o (pin_rise),
    .fall_o (pin_fall)
  );

  always_comb begin
    if (alt_sel)                    src_evt = alt_evt;
    else if (mode_q == MD_CAP_FALL) src_evt = pin_fall;
    else                            src_evt = pin_rise;
    case (mode_q)
      MD_CAP_DIVA: ps_sel = PS_A;
      MD_CAP_DIVB: ps_sel = PS_B;
      default:     ps_sel = PS_ONE;
    endcase
    ps_evt = src_evt & cap_on & ~mode_wr;
    ps_clr = mode_wr | ~cap_on;
  end

  tcc_cap_prescale #(
    .DIV_A (DIV_A),
    .DIV_B (DIV_B)
  ) i_presc (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (ps_clr),
    .evt_i  (ps_evt),
    .sel_i  (ps_sel),
    .fire_o (cap_fire)
  );

  // shared holding register: capture has priority over a software write
  always_comb begin
    val_en = cap_fire | val_wr;
    val_d  = cap_fire ? timer_val : wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      val_q <= '0;
    else if (val_en) val_q <= val_d;
  end

  // compare path
  tcc_cmp_action #(
    .TW (TW)
  ) i_cmp (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_i       (mode_q),
    .mode_wr_i    (mode_wr),
    .mode_wdata_i (mode_wdata),
    .timer_i      (timer_val),
    .ref_i        (val_q),
    .match_o      (cmp_match),
    .pin_o        (out_pin),
    .spec_o       (special_evt)
  );

  // interrupt flag: setting wins over clearing
  always_comb begin
    flag_set = cap_fire | cmp_match;
    if (flag_set)     irq_d = 1'b1;
    else if (irq_clr) irq_d = 1'b0;
    else              irq_d = irq_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  always_comb begin
    irq_flag = irq_q;
    out_en   = mode_drives_pin(mode_q);
    rd_data  = rd_sel ? val_q : {{PAD_W{1'b0}}, mode_q};
  end

  // R12: the flag holds until a clear strobe arrives
  p_flag_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !irq_clr) |=> irq_q);

  // R12: an event in the cycle of a clear still leaves the flag set
  p_set_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
    flag_set |=> irq_q);

  // R2: inactive codes leave the output released and low
  p_inactive_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_is_cap(mode_q) && !mode_is_cmp(mode_q)) |-> (!out_en && !out_pin));

  // R2: the prescaler only fires in a capture mode
  p_cap_in_mode_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cap_fire |-> cap_on);

  // R3: without a capture or write the holding register keeps its value
  p_cap_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_fire && !val_wr) |=> $stable(val_q));

endmodule

// File: tb/test_tcc_unit.sv
module test_tcc_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [15:0] wr_data = '0;
  logic        rd_sel = 1'b0;
  logic [15:0] rd_data;
  logic [15:0] tmr = '0;
  logic        cap_pin = 1'b0;
  logic        alt_sel = 1'b0;
  logic        alt_evt = 1'b0;
  logic        out_pin, out_en, irq_flag, special_evt;
  logic        irq_clr = 1'b0;

  logic        tmr_ld = 1'b0;
  logic        tmr_run = 1'b0;
  logic [15:0] tmr_ldv = '0;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    if (tmr_ld)       tmr <= tmr_ldv;
    else if (tmr_run) tmr <= tmr + 16'd1;
  end

  tcc_unit i_tcc_unit (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_sel      (wr_sel),
    .wr_data     (wr_data),
    .rd_sel      (rd_sel),
    .rd_data     (rd_data),
    .timer_val   (tmr),
    .cap_pin     (cap_pin),
    .alt_sel     (alt_sel),
    .alt_evt     (alt_evt),
    .out_pin     (out_pin),
    .out_en      (out_en),
    .irq_flag    (irq_flag),
    .irq_clr     (irq_clr),
    .special_evt (special_evt)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic sel, input logic [15:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    step(1);
    wr_en = 1'b0;
  endtask

  task automatic clr_irq();
    irq_clr = 1'b1;
    step(1);
    irq_clr = 1'b0;
  endtask

  task automatic tmr_set(input logic [15:0] v, input logic run);
    tmr_ld = 1'b1; tmr_ldv = v; tmr_run = run;
    step(1);
    tmr_ld = 1'b0;
  endtask

  // returns in the match cycle; effects appear one negedge later
  task automatic hit(input logic [15:0] v);
    tmr_set(v - 16'd2, 1'b1);
    step(2);
  endtask

  task automatic pin_pulse();
    cap_pin = 1'b1; step(3);
    cap_pin = 1'b0; step(3);
  endtask

  task automatic alt_pulse();
    alt_evt = 1'b1; step(1);
    alt_evt = 1'b0; step(1);
  endtask

  task automatic t_reset();
    chk("R1 out_pin", out_pin, 0);
    chk("R1 out_en", out_en, 0);
    chk("R1 irq_flag", irq_flag, 0);
    chk("R1 special_evt", special_evt, 0);
    rd_sel = 1'b0; #0.1;
    chk("R1 mode read", rd_data, 0);
    rd_sel = 1'b1; #0.1;
    chk("R1 value read", rd_data, 0);
  endtask

  task automatic t_inactive();
    wr(1'b0, 16'h3);
    wr(1'b1, 16'h0040);
    hit(16'h0040); step(1);
    chk("R2 code 0011 no match flag", irq_flag, 0);
    chk("R2 code 0011 out_en", out_en, 0);
    chk("R2 code 0011 out_pin", out_pin, 0);
    pin_pulse();
    chk("R2 code 0011 no capture flag", irq_flag, 0);
    wr(1'b0, 16'hC);
    hit(16'h0040); step(1);
    pin_pulse();
    chk("R2 code 11xx flag", irq_flag, 0);
    chk("R2 code 11xx out_en", out_en, 0);
    rd_sel = 1'b1; #0.1;
    chk("R2 value untouched", rd_data, 16'h0040);
  endtask

  task automatic t_cap_rise();
    logic [15:0] x;
    tmr_set(16'h0100, 1'b1);
    wr(1'b0, 16'h5);
    step(3);
    clr_irq();
    x = tmr;
    cap_pin = 1'b1;
    step(2);
    chk("R4 no capture before third edge", irq_flag, 0);
    step(1);
    chk("R4 flag on rising capture", irq_flag, 1);
    chk("R4 captured value", rd_data, x + 16'd2);
    clr_irq();
    cap_pin = 1'b0;
    step(4);
    chk("R4 falling edge ignored", irq_flag, 0);
  endtask

  task automatic t_cap_fall();
    logic [15:0] x;
    wr(1'b0, 16'h4);
    clr_irq();
    cap_pin = 1'b1;
    step(4);
    chk("R3 rising edge ignored", irq_flag, 0);
    x = tmr;
    cap_pin = 1'b0;
    step(2);
    chk("R3 no capture before third edge", irq_flag, 0);
    step(1);
    chk("R3 flag on falling capture", irq_flag, 1);
    chk("R3 captured value", rd_data, x + 16'd2);
  endtask

  task automatic t_prescale();
    wr(1'b0, 16'h6);
    clr_irq();
    repeat (3) pin_pulse();
    chk("R5 div4 silent after 3 edges", irq_flag, 0);
    pin_pulse();
    chk("R5 div4 fires on 4th edge", irq_flag, 1);
    clr_irq();
    repeat (2) pin_pulse();
    wr(1'b0, 16'h6);
    repeat (3) pin_pulse();
    chk("R5 mode write restarts count", irq_flag, 0);
    pin_pulse();
    chk("R5 div4 fires after restart", irq_flag, 1);
  endtask

  task automatic t_alt();
    logic [15:0] vb, x;
    alt_sel = 1'b1;
    wr(1'b0, 16'h5);
    clr_irq();
    vb = rd_data;
    pin_pulse();
    chk("R6 pin ignored flag", irq_flag, 0);
    chk("R6 pin ignored value", rd_data, vb);
    x = tmr;
    alt_evt = 1'b1;
    step(1);
    alt_evt = 1'b0;
    chk("R6 alt event flag", irq_flag, 1);
    chk("R6 alt event value", rd_data, x);
    wr(1'b0, 16'h7);
    clr_irq();
    repeat (15) alt_pulse();
    chk("R5 div16 silent after 15", irq_flag, 0);
    alt_pulse();
    chk("R5 div16 fires on 16th", irq_flag, 1);
    alt_sel = 1'b0;
  endtask

  task automatic t_toggle();
    tmr_run = 1'b0;
    wr(1'b0, 16'h2);
    wr(1'b1, 16'h1234);
    clr_irq();
    chk("R7 entry level", out_pin, 0);
    chk("R7 out_en", out_en, 1);
    hit(16'h1234);
    chk("R11 no effect before match edge", out_pin, 0);
    step(1);
    chk("R7 first toggle", out_pin, 1);
    chk("R7 flag", irq_flag, 1);
    hit(16'h1234); step(1);
    chk("R7 second toggle", out_pin, 0);
  endtask

  task automatic t_force();
    wr(1'b0, 16'h8);
    wr(1'b1, 16'h2000);
    clr_irq();
    chk("R8 1000 entry low", out_pin, 0);
    chk("R8 1000 out_en", out_en, 1);
    hit(16'h2000); step(1);
    chk("R8 1000 forced high", out_pin, 1);
    chk("R8 1000 flag", irq_flag, 1);
    wr(1'b0, 16'h9);
    clr_irq();
    chk("R8 1001 entry high", out_pin, 1);
    hit(16'h2000); step(1);
    chk("R8 1001 forced low", out_pin, 0);
    chk("R8 1001 flag", irq_flag, 1);
  endtask

  task automatic t_irq_only();
    wr(1'b0, 16'hA);
    clr_irq();
    chk("R9 out_en released", out_en, 0);
    hit(16'h2000); step(1);
    chk("R9 flag", irq_flag, 1);
    chk("R9 pin unchanged", out_pin, 0);
    chk("R9 no special pulse", special_evt, 0);
  endtask

  task automatic t_special();
    wr(1'b0, 16'hB);
    clr_irq();
    hit(16'h2000);
    chk("R10 no pulse before match edge", special_evt, 0);
    step(1);
    chk("R10 pulse high", special_evt, 1);
    chk("R10 flag", irq_flag, 1);
    step(1);
    chk("R10 pulse one cycle", special_evt, 0);
    chk("R10 out_en released", out_en, 0);
  endtask

  task automatic t_once();
    wr(1'b0, 16'hA);
    wr(1'b1, 16'h3000);
    clr_irq();
    tmr_set(16'h3000, 1'b0);
    step(1);
    chk("R11 match on arrival", irq_flag, 1);
    clr_irq();
    step(5);
    chk("R11 no repeat while equal", irq_flag, 0);
  endtask

  task automatic t_set_wins();
    wr(1'b1, 16'h3100);
    clr_irq();
    hit(16'h3100);
    irq_clr = 1'b1;
    step(1);
    irq_clr = 1'b0;
    chk("R12 set wins over clear", irq_flag, 1);
    step(3);
    chk("R12 flag sticky", irq_flag, 1);
    clr_irq();
    chk("R12 clear strobe", irq_flag, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    step(3);
    t_reset();
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_inactive();
    t_cap_rise();
    t_cap_fall();
    t_prescale();
    t_alt();
    t_toggle();
    t_force();
    t_irq_only();
    t_special();
    t_once();
    t_set_wins();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule